// File: doc/BRIEF.md
# Debug Break Condition Unit

This unit sits beside a processor core and its debug port. Every cycle it looks at the current instruction fetch address, any data memory read or write, any frame memory access, a flag that reports a non-sequential fetch, the retire strobe of the core and a hardware break line that comes from programmable logic. When an armed condition matches, it raises a single halt request and reports which condition caused it.

Software arms the conditions through a small write-only register port. Program and data comparators each match either one address or an inclusive address range. Data comparators also have read and write qualifiers. The frame comparator matches one address only. Single-step mode stops the core after one instruction following each resume. Flow-change mode stops the core on any departure from sequential fetch.

The request is sticky. It holds until software writes the clear bit. All monitored inputs are observations of the core and are sampled every cycle. They carry no valid/ready handshake, and the unit never applies back-pressure to the core.

Top module: `brk_cond_unit`

## Requirements
- R1: Each program comparator, when enabled and `fetch_valid` is high, hits on `fetch_addr`. Config bit 2i+1 of the program config register selects the mode for comparator i: 0 means the address equals low, 1 means low ≤ address ≤ high.
- R2: A range comparator includes both bounds. A range whose low is greater than its high never hits.
- R3: Each data comparator hits only on enabled access kinds. In the data config register, comparator i uses bit 4i for enable, 4i+1 for range, 4i+2 for read and 4i+3 for write.
- R4: With frame enable set, a frame access (`fmem_acc`) hits only when `fmem_addr` equals the programmed frame address.
- R5: With flow enable set, a `flow_chg` pulse raises a break.
- R6: `ext_brk_in` passes through a two-flop synchroniser. With external enable set, `brk_req` rises on the third rising edge at which the input is high.
- R7: With step enable set, each resume arms the step condition. A resume is a fall of `core_halted`. The first `insn_done` after that, and only that one, raises a break.
- R8: A condition whose enable bit is clear never raises a break.
- R9: When several conditions hit in one cycle, the cause reports the highest one. The codes, from highest to lowest priority, are external 1, program 2, data 3, frame 4, flow change 5 and single step 6. Code 0 means no break.
- R10: `brk_req` and `brk_cause` hold their values until a control write with bit 4 set. That write drives both to 0 on the same edge.
- R11: While `core_halted` is high, no condition can raise a break.
- R12: After reset, `brk_req` is 0, `brk_cause` is 0 and every condition is disabled.
- R13: The register map is as follows. Address 0 is control: bit 0 external, 1 flow, 2 step, 3 frame, 4 clear. Address 1 is the frame address. Program comparator i uses low at 2+2i and high at 3+2i. Address 8 is program config and address 9 is data config. Data comparator i uses low at 10+2i and high at 11+2i. A write is taken on a rising edge with `reg_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | REG_W | Register write data |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | PA_W | Program fetch address |
| dmem_rd | input | 1 | Data memory read this cycle |
| dmem_wr | input | 1 | Data memory write this cycle |
| dmem_addr | input | DA_W | Data memory address |
| flow_chg | input | 1 | Fetch is not sequential this cycle |
| fmem_acc | input | 1 | Frame memory access this cycle |
| fmem_addr | input | FA_W | Frame memory address |
| ext_brk_in | input | 1 | Asynchronous break line from programmable logic |
| insn_done | input | 1 | An instruction completed this cycle |
| core_halted | input | 1 | Core is in the halted state |
| brk_req | output | 1 | Sticky halt request |
| brk_cause | output | 3 | Cause code of the request |

## Verification
The program comparators are driven from a table of fetch addresses. The table places addresses exactly on each bound of a range, one step outside each bound, inside an inverted range, and on a degenerate range whose low equals its high. This separates inclusive bounds from exclusive ones and separates a single-address match from a range match. Data accesses are applied as reads and as writes against read-only and write-only comparators, so a wrong qualifier polarity shows up directly. Several conditions are applied in the same cycle to confirm the priority order. Single step is run across two resumes with an extra retire in between, which separates a one-shot break from a level-triggered one.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_EXT   = 3'd1,
    CAUSE_PROG  = 3'd2,
    CAUSE_DATA  = 3'd3,
    CAUSE_FRAME = 3'd4,
    CAUSE_FLOW  = 3'd5,
    CAUSE_STEP  = 3'd6
  } brk_cause_e;

  localparam int unsigned REG_AW  = 4;
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_FRAME = 1;
  localparam int unsigned A_PBASE = 2;
  localparam int unsigned A_PCFG  = 8;
  localparam int unsigned A_DCFG  = 9;
  localparam int unsigned A_DBASE = 10;

  localparam int unsigned CB_EXT   = 0;
  localparam int unsigned CB_FLOW  = 1;
  localparam int unsigned CB_STEP  = 2;
  localparam int unsigned CB_FRAME = 3;
  localparam int unsigned CB_CLEAR = 4;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int unsigned REG_W = 16,
  parameter int unsigned N_PBP = 2,
  parameter int unsigned N_DBP = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [REG_AW-1:0]            addr,
  input  logic [REG_W-1:0]             wdata,
  output logic                         ext_en,
  output logic                         flow_en,
  output logic                         step_en,
  output logic                         frame_en,
  output logic                         clr_pulse,
  output logic [REG_W-1:0]             frame_addr,
  output logic [N_PBP-1:0][REG_W-1:0]  p_lo,
  output logic [N_PBP-1:0][REG_W-1:0]  p_hi,
  output logic [N_PBP-1:0]             p_en,
  output logic [N_PBP-1:0]             p_rng,
  output logic [N_DBP-1:0][REG_W-1:0]  d_lo,
  output logic [N_DBP-1:0][REG_W-1:0]  d_hi,
  output logic [N_DBP-1:0]             d_en,
  output logic [N_DBP-1:0]             d_rng,
  output logic [N_DBP-1:0]             d_rd,
  output logic [N_DBP-1:0]             d_wr
);
  localparam int unsigned PCFG_W = 2 * N_PBP;
  localparam int unsigned DCFG_W = 4 * N_DBP;

  logic [3:0]        ctrl_q;
  logic [REG_W-1:0]  frame_q;
  logic [PCFG_W-1:0] pcfg_q;
  logic [DCFG_W-1:0] dcfg_q;

  logic wr_ctrl;
  assign wr_ctrl   = we && (addr == REG_AW'(A_CTRL));
  assign clr_pulse = wr_ctrl && wdata[CB_CLEAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      frame_q <= '0;
      pcfg_q  <= '0;
      dcfg_q  <= '0;
    end else if (we) begin
      if (wr_ctrl)                     ctrl_q  <= wdata[3:0];
      if (addr == REG_AW'(A_FRAME))    frame_q <= wdata;
      if (addr == REG_AW'(A_PCFG))     pcfg_q  <= wdata[PCFG_W-1:0];
      if (addr == REG_AW'(A_DCFG))     dcfg_q  <= wdata[DCFG_W-1:0];
    end
  end

  assign ext_en     = ctrl_q[CB_EXT];
  assign flow_en    = ctrl_q[CB_FLOW];
  assign step_en    = ctrl_q[CB_STEP];
  assign frame_en   = ctrl_q[CB_FRAME];
  assign frame_addr = frame_q;

  for (genvar i = 0; i < N_PBP; i++) begin : g_preg
    localparam logic [REG_AW-1:0] LO_A = REG_AW'(A_PBASE + 2 * i);
    localparam logic [REG_AW-1:0] HI_A = REG_AW'(A_PBASE + 2 * i + 1);
    logic [REG_W-1:0] lo_q, hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we) begin
        if (addr == LO_A) lo_q <= wdata;
        if (addr == HI_A) hi_q <= wdata;
      end
    end
    assign p_lo[i]  = lo_q;
    assign p_hi[i]  = hi_q;
    assign p_en[i]  = pcfg_q[2*i];
    assign p_rng[i] = pcfg_q[2*i+1];
  end

  for (genvar i = 0; i < N_DBP; i++) begin : g_dreg
    localparam logic [REG_AW-1:0] LO_A = REG_AW'(A_DBASE + 2 * i);
    localparam logic [REG_AW-1:0] HI_A = REG_AW'(A_DBASE + 2 * i + 1);
    logic [REG_W-1:0] lo_q, hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we) begin
        if (addr == LO_A) lo_q <= wdata;
        if (addr == HI_A) hi_q <= wdata;
      end
    end
    assign d_lo[i]  = lo_q;
    assign d_hi[i]  = hi_q;
    assign d_en[i]  = dcfg_q[4*i];
    assign d_rng[i] = dcfg_q[4*i+1];
    assign d_rd[i]  = dcfg_q[4*i+2];
    assign d_wr[i]  = dcfg_q[4*i+3];
  end

  // R13: a clear write must never leave the clear bit in control storage
  a_r13_ctrl_width: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (ctrl_q == $past(wdata[3:0])));
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
  parameter int unsigned W = 16
) (
  input  logic         en,
  input  logic         rng,
  input  logic         qual,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] addr,
  output logic         hit
);
  logic in_range, on_point;

  always_comb begin
    in_range = (addr >= lo) && (addr <= hi);
    on_point = (addr == lo);
    hit      = en && qual && (rng ? in_range : on_point);
  end
endmodule

// File: rtl/brk_sync.sv
module brk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/brk_step.sv
module brk_step (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic core_halted,
  input  logic insn_done,
  output logic step_hit
);
  logic halted_q, armed_q, resume;

  assign resume   = halted_q && !core_halted;
  assign step_hit = step_en && (armed_q || resume) && insn_done && !core_halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      halted_q <= core_halted;
      if (core_halted || step_hit) armed_q <= 1'b0;
      else if (resume)             armed_q <= 1'b1;
    end
  end

  // R7: a single resume yields at most one step break
  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    step_hit |=> !step_hit);
endmodule

// File: rtl/brk_cond_unit.sv
module brk_cond_unit
  import brk_pkg::*;
#(
  parameter int unsigned REG_W = 16,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned DA_W  = 16,
  parameter int unsigned FA_W  = 12,
  parameter int unsigned N_PBP = 2,
  parameter int unsigned N_DBP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              fetch_valid,
  input  logic [PA_W-1:0]   fetch_addr,
  input  logic              dmem_rd,
  input  logic              dmem_wr,
  input  logic [DA_W-1:0]   dmem_addr,
  input  logic              flow_chg,
  input  logic              fmem_acc,
  input  logic [FA_W-1:0]   fmem_addr,
  input  logic              ext_brk_in,
  input  logic              insn_done,
  input  logic              core_halted,
  output logic              brk_req,
  output logic [2:0]        brk_cause
);
  logic ext_en, flow_en, step_en, frame_en, clr_pulse;
  logic [REG_W-1:0]            frame_addr;
  logic [N_PBP-1:0][REG_W-1:0] p_lo, p_hi;
  logic [N_PBP-1:0]            p_en, p_rng, p_hit;
  logic [N_DBP-1:0][REG_W-1:0] d_lo, d_hi;
  logic [N_DBP-1:0]            d_en, d_rng, d_rd, d_wr, d_hit;

  brk_regs #(.REG_W(REG_W), .N_PBP(N_PBP), .N_DBP(N_DBP)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ext_en(ext_en), .flow_en(flow_en), .step_en(step_en), .frame_en(frame_en),
    .clr_pulse(clr_pulse), .frame_addr(frame_addr),
    .p_lo(p_lo), .p_hi(p_hi), .p_en(p_en), .p_rng(p_rng),
    .d_lo(d_lo), .d_hi(d_hi), .d_en(d_en), .d_rng(d_rng), .d_rd(d_rd), .d_wr(d_wr)
  );

  logic [REG_W-1:0] fa_x, da_x, ma_x;
  assign fa_x = REG_W'(fetch_addr);
  assign da_x = REG_W'(dmem_addr);
  assign ma_x = REG_W'(fmem_addr);

  for (genvar i = 0; i < N_PBP; i++) begin : g_pcmp
    brk_addr_cmp #(.W(REG_W)) u_cmp (
      .en(p_en[i]), .rng(p_rng[i]), .qual(fetch_valid),
      .lo(p_lo[i]), .hi(p_hi[i]), .addr(fa_x), .hit(p_hit[i])
    );
    // R2: an inverted range must never produce a hit
    a_r2_empty_range: assert property (@(posedge clk) disable iff (!rst_n)
      (p_rng[i] && (p_lo[i] > p_hi[i])) |-> !p_hit[i]);
  end

  for (genvar i = 0; i < N_DBP; i++) begin : g_dcmp
    logic qual;
    assign qual = (dmem_rd && d_rd[i]) || (dmem_wr && d_wr[i]);
    brk_addr_cmp #(.W(REG_W)) u_cmp (
      .en(d_en[i]), .rng(d_rng[i]), .qual(qual),
      .lo(d_lo[i]), .hi(d_hi[i]), .addr(da_x), .hit(d_hit[i])
    );
    // R3: no data hit without an access of an enabled kind
    a_r3_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      d_hit[i] |-> ((dmem_rd && d_rd[i]) || (dmem_wr && d_wr[i])));
  end

  logic ext_s;
  brk_sync u_sync (.clk(clk), .rst_n(rst_n), .d(ext_brk_in), .q(ext_s));

  logic step_hit;
  brk_step u_step (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .core_halted(core_halted),
    .insn_done(insn_done), .step_hit(step_hit)
  );

  logic ext_hit, frame_hit, flow_hit;
  assign ext_hit   = ext_en && ext_s;
  assign frame_hit = frame_en && fmem_acc && (ma_x == frame_addr);
  assign flow_hit  = flow_en && flow_chg;

  brk_cause_e cause_n, cause_q;
  logic       req_q, eval;

  always_comb begin
    if (ext_hit)        cause_n = CAUSE_EXT;
    else if (|p_hit)    cause_n = CAUSE_PROG;
    else if (|d_hit)    cause_n = CAUSE_DATA;
    else if (frame_hit) cause_n = CAUSE_FRAME;
    else if (flow_hit)  cause_n = CAUSE_FLOW;
    else if (step_hit)  cause_n = CAUSE_STEP;
    else                cause_n = CAUSE_NONE;
  end

  assign eval = !core_halted && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (clr_pulse) begin
      req_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (eval && (cause_n != CAUSE_NONE)) begin
      req_q   <= 1'b1;
      cause_q <= cause_n;
    end
  end

  assign brk_req   = req_q;
  assign brk_cause = cause_q;

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !clr_pulse) |=> req_q);
  a_r10_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !clr_pulse) |=> $stable(cause_q));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (!req_q && cause_q == CAUSE_NONE));
  a_r11_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halted && !req_q) |=> !req_q);
  a_r9_cause_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (cause_q != CAUSE_NONE));
  a_r8_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && !req_q && !clr_pulse) |=> !(req_q && cause_q == CAUSE_EXT));
endmodule

// File: tb/tb_brk_cond_unit.sv
module tb_brk_cond_unit;
  localparam int CLK_P = 10;
  localparam int NV    = 10;
  // {cmp, rng, lo, hi, addr, hit}
  localparam logic [50:0] PV [0:NV-1] = '{
    {1'b0, 1'b0, 16'h0100, 16'h0000, 16'h0100, 1'b1},
    {1'b0, 1'b0, 16'h0100, 16'h0000, 16'h0101, 1'b0},
    {1'b0, 1'b1, 16'h0200, 16'h0210, 16'h0200, 1'b1},
    {1'b0, 1'b1, 16'h0200, 16'h0210, 16'h0210, 1'b1},
    {1'b0, 1'b1, 16'h0200, 16'h0210, 16'h0211, 1'b0},
    {1'b0, 1'b1, 16'h0200, 16'h0210, 16'h01FF, 1'b0},
    {1'b0, 1'b1, 16'h0300, 16'h0200, 16'h0250, 1'b0},
    {1'b0, 1'b1, 16'h0400, 16'h0400, 16'h0400, 1'b1},
    {1'b1, 1'b0, 16'h0ABC, 16'h0000, 16'h0ABC, 1'b1},
    {1'b1, 1'b1, 16'h1000, 16'h2000, 16'h1800, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic fetch_valid = 1'b0, dmem_rd = 1'b0, dmem_wr = 1'b0, flow_chg = 1'b0;
  logic fmem_acc = 1'b0, ext_brk_in = 1'b0, insn_done = 1'b0, core_halted = 1'b0;
  logic [15:0] fetch_addr = '0, dmem_addr = '0;
  logic [11:0] fmem_addr = '0;
  logic brk_req;
  logic [2:0] brk_cause;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  brk_cond_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .dmem_addr(dmem_addr), .flow_chg(flow_chg), .fmem_acc(fmem_acc), .fmem_addr(fmem_addr),
    .ext_brk_in(ext_brk_in), .insn_done(insn_done), .core_halted(core_halted),
    .brk_req(brk_req), .brk_cause(brk_cause)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic expect_brk(input string tag, input logic r, input logic [2:0] c);
    chk({tag, " req"}, 16'(brk_req), 16'(r));
    chk({tag, " cause"}, 16'(brk_cause), 16'(c));
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    expect_brk("R12 reset", 1'b0, 3'd0);

    // R8: comparator loaded but not enabled; external line high while disabled
    wr(4'd2, 16'h0100);
    fetch_valid = 1'b1; fetch_addr = 16'h0100; tick(); fetch_valid = 1'b0;
    expect_brk("R8 prog disabled", 1'b0, 3'd0);
    ext_brk_in = 1'b1;
    repeat (4) tick();
    expect_brk("R8 ext disabled", 1'b0, 3'd0);

    // R9: external beats program and flow change
    wr(4'd8, 16'h0001);
    wr(4'd0, 16'h0003);
    flow_chg = 1'b1; fetch_valid = 1'b1; fetch_addr = 16'h0100; tick();
    flow_chg = 1'b0; fetch_valid = 1'b0; ext_brk_in = 1'b0;
    expect_brk("R9 ext first", 1'b1, 3'd1);
    wr(4'd0, 16'h0010);
    expect_brk("R10 clear", 1'b0, 3'd0);

    // R1/R2: table of program comparator vectors
    for (int k = 0; k < NV; k++) begin
      logic [50:0] v;
      logic [3:0] la;
      v = PV[k];
      la = v[50] ? 4'd4 : 4'd2;
      wr(4'd8, 16'h0000);
      wr(la, v[48:33]);
      wr(la + 4'd1, v[32:17]);
      wr(4'd8, v[50] ? {12'h0, v[49], 3'b100} : {14'h0, v[49], 1'b1});
      fetch_valid = 1'b1; fetch_addr = v[16:1]; tick(); fetch_valid = 1'b0;
      expect_brk($sformatf("R1 R2 vector %0d", k), v[0], v[0] ? 3'd2 : 3'd0);
      wr(4'd0, 16'h0010);
    end
    wr(4'd8, 16'h0000);

    // R3: comp0 single 0x40 read-only, comp1 range 0x80..0x8F write-only
    wr(4'd10, 16'h0040);
    wr(4'd12, 16'h0080);
    wr(4'd13, 16'h008F);
    wr(4'd9, 16'h00B5);
    dmem_wr = 1'b1; dmem_addr = 16'h0040; tick(); dmem_wr = 1'b0;
    expect_brk("R3 write on read-only", 1'b0, 3'd0);
    dmem_rd = 1'b1; tick(); dmem_rd = 1'b0;
    expect_brk("R3 read hit", 1'b1, 3'd3);
    wr(4'd0, 16'h0010);
    dmem_rd = 1'b1; dmem_addr = 16'h0085; tick(); dmem_rd = 1'b0;
    expect_brk("R3 read on write-only", 1'b0, 3'd0);
    dmem_wr = 1'b1; tick(); dmem_wr = 1'b0;
    expect_brk("R3 write range hit", 1'b1, 3'd3);
    wr(4'd0, 16'h0010);
    dmem_wr = 1'b1; dmem_addr = 16'h0090; tick(); dmem_wr = 1'b0;
    expect_brk("R3 outside range", 1'b0, 3'd0);

    // R9/R4/R5: data over frame over flow
    wr(4'd1, 16'h0123);
    wr(4'd0, 16'h000A);
    dmem_wr = 1'b1; dmem_addr = 16'h0085; fmem_acc = 1'b1; fmem_addr = 12'h123; flow_chg = 1'b1;
    tick();
    dmem_wr = 1'b0;
    expect_brk("R9 data over frame", 1'b1, 3'd3);
    wr(4'd0, 16'h001A);
    tick();
    expect_brk("R9 frame over flow", 1'b1, 3'd4);
    wr(4'd0, 16'h001A);
    fmem_addr = 12'h124; flow_chg = 1'b0; tick(); fmem_acc = 1'b0;
    expect_brk("R4 frame miss", 1'b0, 3'd0);
    flow_chg = 1'b1; tick(); flow_chg = 1'b0;
    expect_brk("R5 flow change", 1'b1, 3'd5);
    wr(4'd0, 16'h0018);
    flow_chg = 1'b1; tick(); flow_chg = 1'b0;
    expect_brk("R8 flow disabled", 1'b0, 3'd0);

    // R9: program over data
    wr(4'd2, 16'h0100);
    wr(4'd8, 16'h0001);
    fetch_valid = 1'b1; fetch_addr = 16'h0100; dmem_wr = 1'b1; dmem_addr = 16'h0085; tick();
    fetch_valid = 1'b0; dmem_wr = 1'b0;
    expect_brk("R9 prog over data", 1'b1, 3'd2);
    wr(4'd8, 16'h0000);
    wr(4'd0, 16'h0012);

    // R10: sticky with frozen cause
    flow_chg = 1'b1; tick(); flow_chg = 1'b0;
    expect_brk("R10 first", 1'b1, 3'd5);
    dmem_wr = 1'b1; dmem_addr = 16'h0085; tick(); tick(); dmem_wr = 1'b0;
    expect_brk("R10 held", 1'b1, 3'd5);
    wr(4'd0, 16'h0012);
    expect_brk("R10 cleared", 1'b0, 3'd0);

    // R11: halted core ignores conditions
    core_halted = 1'b1; flow_chg = 1'b1; tick(); tick(); flow_chg = 1'b0;
    expect_brk("R11 halted", 1'b0, 3'd0);

    // R7: single step across resumes
    wr(4'd0, 16'h0014);
    insn_done = 1'b1; tick(); insn_done = 1'b0;
    expect_brk("R7 halted retire", 1'b0, 3'd0);
    core_halted = 1'b0; tick(); tick();
    expect_brk("R7 armed idle", 1'b0, 3'd0);
    insn_done = 1'b1; tick(); insn_done = 1'b0;
    expect_brk("R7 step", 1'b1, 3'd6);
    wr(4'd0, 16'h0014);
    insn_done = 1'b1; tick(); insn_done = 1'b0;
    expect_brk("R7 no second", 1'b0, 3'd0);
    core_halted = 1'b1; tick(); core_halted = 1'b0; tick();
    insn_done = 1'b1; tick(); insn_done = 1'b0;
    expect_brk("R7 rearm", 1'b1, 3'd6);

    // R6: synchroniser latency
    wr(4'd0, 16'h0011);
    ext_brk_in = 1'b1;
    tick();
    chk("R6 edge1", 16'(brk_req), 16'd0);
    tick();
    chk("R6 edge2", 16'(brk_req), 16'd0);
    tick();
    expect_brk("R6 edge3", 1'b1, 3'd1);
    ext_brk_in = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule